// File: doc/BRIEF.md
# Partitionable Multi-Mode Lookup Table Cell

This cell holds a 64-bit truth table and evaluates it against two 5-bit logic buses, `a` and `b`, plus a control bit `c0`. The table is split into two fixed 32-bit halves. Each half is made of two 16-entry quarters. A 2-bit mode input sets how the same inputs are routed into the quarters. The cell can act as four 4-input functions, as two 5-input functions, or as one 6-input function in which `c0` is the sixth input.

The table is loaded through a clocked word-write port, one word per cycle. All function outputs are combinational from the present inputs and the stored table. A surrounding fabric can therefore reprogram the cell and read its outputs with no output latency.

Top module: `plut_cell`

## Requirements
- R1: While `rst_n` is low, and after it rises, every table bit is 0, so every output reads 0 until a word is written.
- R2: When `cfg_we` is high at a rising clock edge, word `cfg_addr` is loaded with `cfg_wdata`. Word k holds table bits k*W+W-1 down to k*W, where W is the word width. All other words keep their contents.
- R3: Quarter 0 is table bits 15:0 and drives `f[0]`. Quarter 1 is bits 31:16 and drives `f[1]`. Quarter 2 is bits 47:32 and drives `f[2]`. Quarter 3 is bits 63:48 and drives `f[3]`. Half B is quarters 0 and 1; half A is quarters 2 and 3. Within a quarter, the output is the bit whose index equals its 4-bit address.
- R4: In mode 0 (four functions), the quarter addresses, each listed MSB first, are:
  - quarter 0: {b[3],b[2],b[1],b[0]}
  - quarter 1: {b[4],b[2],b[1],b[0]}
  - quarter 2: {a[3],a[2],a[1],a[0]}
  - quarter 3: {a[4],a[2],a[1],a[0]}

  Bits [2:0] of a bus are shared by both quarters of its half. `fa5`, `fb5` and `fw` are 0.
- R5: In mode 1 (two functions), quarters 0 and 1 are addressed by `b[3:0]`, and quarters 2 and 3 by `a[3:0]`. `fa5` equals table bit 32+a, and `fb5` equals table bit b; the fifth input picks the upper quarter of its half. `fw` is 0.
- R6: In mode 2 (one wide function), all four quarters are addressed by `a[3:0]`. `fa5` equals table bit 32+a and `fb5` equals table bit a. `fw` equals table bit {c,a[4:0]}, where c is `c0` AND `c0_en`, so c=1 selects half A.
- R7: When `c0_en` is 0, `c0` has no effect: in mode 2, `fw` equals `fb5` whatever `c0` is.
- R8: All function outputs follow input changes without a clock edge.
- R9: Mode 3 behaves exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the table write port |
| rst_n | input | 1 | Asynchronous active-low reset, clears the table |
| cfg_we | input | 1 | Table word write enable |
| cfg_addr | input | CFG_AW (3) | Table word index |
| cfg_wdata | input | CFG_WORD_W (8) | Table word data |
| mode | input | 2 | 0/3 four functions, 1 two functions, 2 one wide function |
| a | input | 5 | Logic bus feeding half A |
| b | input | 5 | Logic bus feeding half B |
| c0 | input | 1 | Sixth input for the wide function |
| c0_en | input | 1 | Enables `c0`; when 0, `c0` is read as 0 |
| f | output | 4 | Quarter outputs, bit q from quarter q |
| fa5 | output | 1 | 5-input result of half A |
| fb5 | output | 1 | 5-input result of half B |
| fw | output | 1 | 6-input wide result |

## Verification
The bench uses the default word width of 8, so the table is eight words. Every 16-bit quarter then spans exactly two words.

This alignment lets a single word rewrite change only the upper eight entries of one quarter. The bench can then confirm that neighbouring entries and the other half are untouched. With the table fixed at a distinct, irregular pattern, each table vector sets inputs whose bit indices land on both 0 and 1 entries. A wrong address bit, a swapped half or a mis-wired fifth input therefore shows up at the outputs.

// File: rtl/plut_pkg.sv
package plut_pkg;

  localparam int QUARTER_IN   = 4;
  localparam int QUARTER_BITS = 1 << QUARTER_IN;
  localparam int NUM_QUARTERS = 4;
  localparam int TABLE_BITS   = QUARTER_BITS * NUM_QUARTERS;
  localparam int BUS_W        = QUARTER_IN + 1;

  typedef enum logic [1:0] {
    MODE_QUAD     = 2'd0,
    MODE_PAIR     = 2'd1,
    MODE_WIDE     = 2'd2,
    MODE_QUAD_ALT = 2'd3
  } plut_mode_e;

  // Address of a quarter when the four quarters act as separate functions:
  // the low three bus bits are shared, the fourth comes from bit 3 (lower
  // quarter) or bit 4 (upper quarter).
  function automatic logic [QUARTER_IN-1:0] split_addr(
      input logic [BUS_W-1:0] bus, input logic upper);
    return {upper ? bus[BUS_W-1] : bus[BUS_W-2], bus[QUARTER_IN-2:0]};
  endfunction

  // Address of a quarter when it is half of a 5-input function.
  function automatic logic [QUARTER_IN-1:0] joint_addr(input logic [BUS_W-1:0] bus);
    return bus[QUARTER_IN-1:0];
  endfunction

endpackage

// File: rtl/plut_cfg_store.sv
module plut_cfg_store #(
  parameter int TABLE_BITS = 64,
  parameter int WORD_W     = 8,
  localparam int WORDS     = TABLE_BITS / WORD_W,
  localparam int AW        = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [TABLE_BITS-1:0] table_bits
);

  logic [WORDS-1:0] wr_hit;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;

    assign wr_hit[k] = we && (addr == AW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (wr_hit[k]) word_q <= wdata;
    end

    assign table_bits[k*WORD_W +: WORD_W] = word_q;

    p_word_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[k] |=> (table_bits[k*WORD_W +: WORD_W] == $past(wdata)));

    p_word_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[k] |=> $stable(table_bits[k*WORD_W +: WORD_W]));
  end

  p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: rtl/plut_quarter.sv
module plut_quarter #(
  parameter int IN_W = 4,
  localparam int DEPTH = 1 << IN_W
) (
  input  logic [DEPTH-1:0] bits,
  input  logic [IN_W-1:0]  sel,
  output logic             y
);
  assign y = bits[sel];
endmodule

// File: rtl/plut_half.sv
module plut_half (
  input  logic lower,
  input  logic upper,
  input  logic pick_upper,
  output logic y
);
  assign y = pick_upper ? upper : lower;
endmodule

// File: rtl/plut_cell.sv
module plut_cell
  import plut_pkg::*;
#(
  parameter int CFG_WORD_W = 8,
  localparam int CFG_WORDS = TABLE_BITS / CFG_WORD_W,
  localparam int CFG_AW    = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFG_WORD_W-1:0] cfg_wdata,
  input  logic [1:0]            mode,
  input  logic [BUS_W-1:0]      a,
  input  logic [BUS_W-1:0]      b,
  input  logic                  c0,
  input  logic                  c0_en,
  output logic [NUM_QUARTERS-1:0] f,
  output logic                  fa5,
  output logic                  fb5,
  output logic                  fw
);

  logic [TABLE_BITS-1:0] table_bits;
  plut_mode_e            mode_e;
  logic                  quad_mode, pair_mode, wide_mode;
  logic                  c0_eff;
  logic [QUARTER_IN-1:0] q_sel [NUM_QUARTERS];
  logic [NUM_QUARTERS-1:0] q_out;
  logic                  half_a_pick, half_b_pick;
  logic                  half_a_raw, half_b_raw;

  plut_cfg_store #(.TABLE_BITS(TABLE_BITS), .WORD_W(CFG_WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .table_bits(table_bits)
  );

  assign mode_e    = plut_mode_e'(mode);
  assign pair_mode = (mode_e == MODE_PAIR);
  assign wide_mode = (mode_e == MODE_WIDE);
  assign quad_mode = !pair_mode && !wide_mode;
  assign c0_eff    = c0 && c0_en;

  // Quarter address routing by mode; quarters 0/1 belong to half B, 2/3 to half A.
  always_comb begin
    unique case (mode_e)
      MODE_PAIR: begin
        q_sel[0] = joint_addr(b);
        q_sel[1] = joint_addr(b);
        q_sel[2] = joint_addr(a);
        q_sel[3] = joint_addr(a);
      end
      MODE_WIDE: begin
        for (int q = 0; q < NUM_QUARTERS; q++) q_sel[q] = joint_addr(a);
      end
      default: begin
        q_sel[0] = split_addr(b, 1'b0);
        q_sel[1] = split_addr(b, 1'b1);
        q_sel[2] = split_addr(a, 1'b0);
        q_sel[3] = split_addr(a, 1'b1);
      end
    endcase
  end

  for (genvar q = 0; q < NUM_QUARTERS; q++) begin : g_quarter
    plut_quarter #(.IN_W(QUARTER_IN)) u_q (
      .bits(table_bits[q*QUARTER_BITS +: QUARTER_BITS]),
      .sel (q_sel[q]),
      .y   (q_out[q])
    );
  end

  assign half_a_pick = a[BUS_W-1];
  assign half_b_pick = wide_mode ? a[BUS_W-1] : b[BUS_W-1];

  plut_half u_half_a (.lower(q_out[2]), .upper(q_out[3]),
                      .pick_upper(half_a_pick), .y(half_a_raw));
  plut_half u_half_b (.lower(q_out[0]), .upper(q_out[1]),
                      .pick_upper(half_b_pick), .y(half_b_raw));

  assign f   = q_out;
  assign fa5 = !quad_mode && half_a_raw;
  assign fb5 = !quad_mode && half_b_raw;
  assign fw  = wide_mode && (c0_eff ? half_a_raw : half_b_raw);

  p_quad_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |-> (!fa5 && !fb5 && !fw));

  p_pair_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !a[4]) |-> (fa5 == f[2]));

  p_pair_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && b[4]) |-> (fb5 == f[1]));

  p_wide_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && c0 && c0_en) |-> (fw == fa5));

  p_c0_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !c0_en) |-> (fw == fb5));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (f == '0 && !fa5 && !fb5 && !fw));

endmodule

// File: tb/plut_cell_bench.sv
module plut_cell_bench;

  localparam logic [63:0] PATTERN = 64'hA5C3_0F96_7E18_D24B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] mode = '0;
  logic [4:0] a = '0, b = '0;
  logic       c0 = 1'b0, c0_en = 1'b0;
  logic [3:0] f;
  logic       fa5, fb5, fw;

  int checks = 0;
  int failures = 0;
  logic [63:0] ref_tab = '0;

  always #5 clk = ~clk;

  plut_cell u_plut_cell (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mode(mode), .a(a), .b(b), .c0(c0),
    .c0_en(c0_en), .f(f), .fa5(fa5), .fb5(fb5), .fw(fw)
  );

  // Stimulus vectors: {mode, a, b, c0, c0_en}
  localparam int NV = 16;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 5'd3,  5'd17, 1'b0, 1'b0},  // R4
    {2'd0, 5'd28, 5'd9,  1'b1, 1'b1},  // R4
    {2'd0, 5'd21, 5'd30, 1'b0, 1'b1},  // R4
    {2'd1, 5'd7,  5'd18, 1'b0, 1'b0},  // R5
    {2'd1, 5'd25, 5'd4,  1'b1, 1'b1},  // R5
    {2'd1, 5'd16, 5'd31, 1'b0, 1'b0},  // R5
    {2'd2, 5'd5,  5'd0,  1'b1, 1'b1},  // R6
    {2'd2, 5'd22, 5'd13, 1'b1, 1'b1},  // R6
    {2'd2, 5'd11, 5'd27, 1'b0, 1'b1},  // R6
    {2'd2, 5'd30, 5'd2,  1'b0, 1'b1},  // R6
    {2'd2, 5'd9,  5'd0,  1'b1, 1'b0},  // R7
    {2'd2, 5'd19, 5'd8,  1'b1, 1'b0},  // R7
    {2'd3, 5'd3,  5'd17, 1'b0, 1'b0},  // R9
    {2'd3, 5'd28, 5'd9,  1'b1, 1'b1},  // R9
    {2'd3, 5'd14, 5'd23, 1'b1, 1'b0},  // R9
    {2'd1, 5'd0,  5'd15, 1'b1, 1'b1}   // R5
  };

  // Reference: {fw, fb5, fa5, f[3:0]} as direct bit picks from the 64-bit table.
  function automatic logic [6:0] expect_out(input logic [63:0] t, input logic [1:0] md,
      input logic [4:0] av, input logic [4:0] bv, input logic cv, input logic ev);
    logic [6:0] r;
    int sel;
    r = '0;
    case (md)
      2'd1: begin
        r[0] = t[bv[3:0]];
        r[1] = t[16 + int'(bv[3:0])];
        r[2] = t[32 + int'(av[3:0])];
        r[3] = t[48 + int'(av[3:0])];
        r[4] = t[32 + int'(av)];
        r[5] = t[bv];
      end
      2'd2: begin
        r[0] = t[av[3:0]];
        r[1] = t[16 + int'(av[3:0])];
        r[2] = t[32 + int'(av[3:0])];
        r[3] = t[48 + int'(av[3:0])];
        r[4] = t[32 + int'(av)];
        r[5] = t[av];
        sel = ((cv && ev) ? 32 : 0) + int'(av);
        r[6] = t[sel];
      end
      default: begin
        r[0] = t[{bv[3], bv[2:0]}];
        r[1] = t[16 + int'({bv[4], bv[2:0]})];
        r[2] = t[32 + int'({av[3], av[2:0]})];
        r[3] = t[48 + int'({av[4], av[2:0]})];
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] md, input logic ev);
    case (md)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return ev ? "R6" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] exp_v);
    logic [6:0] act;
    act = {fw, fb5, fa5, f};
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s mode=%0d a=%0d b=%0d c0=%0b en=%0b actual=%b expected=%b",
               req, mode, a, b, c0, c0_en, act, exp_v);
    end
  endtask

  task automatic drive(input logic [1:0] md, input logic [4:0] av, input logic [4:0] bv,
                       input logic cv, input logic ev);
    mode = md; a = av; b = bv; c0 = cv; c0_en = ev;
    #1;
  endtask

  task automatic write_word(input logic [2:0] ad, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    ref_tab[8*int'(ad) +: 8] = d;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, table cleared
    repeat (2) @(negedge clk);
    drive(2'd2, 5'd31, 5'd31, 1'b1, 1'b1);
    check("R1", 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(2'd1, 5'd17, 5'd3, 1'b0, 1'b0);
    check("R1", 7'b0);

    // R2: load the table word by word
    for (int k = 0; k < 8; k++) write_word(3'(k), PATTERN[8*k +: 8]);

    // R3: quarter layout, one entry at a time in mode 0
    for (int e = 0; e < 16; e += 5) begin
      drive(2'd0, {1'b0, 4'(e)}, {1'b0, 4'(e)}, 1'b0, 1'b0);
      check("R3", {3'b0, PATTERN[48 + int'({1'b0, 3'(e)})], PATTERN[32 + e],
                   PATTERN[16 + int'({1'b0, 3'(e)})], PATTERN[e]});
    end

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v][13:12], VEC[v][11:7], VEC[v][6:2], VEC[v][1], VEC[v][0]);
      check(tag_of(VEC[v][13:12], VEC[v][0]),
            expect_out(ref_tab, VEC[v][13:12], VEC[v][11:7], VEC[v][6:2], VEC[v][1], VEC[v][0]));
    end

    // R7: c0 toggled with c0_en low leaves fw on half B
    for (int a_i = 0; a_i < 32; a_i += 7) begin
      drive(2'd2, 5'(a_i), 5'd0, 1'b1, 1'b0);
      check("R7", expect_out(ref_tab, 2'd2, 5'(a_i), 5'd0, 1'b0, 1'b0));
    end

    // R2: rewrite word 5 only (Q2 entries 8..15); other entries unchanged
    write_word(3'd5, 8'h00);
    drive(2'd2, 5'd12, 5'd0, 1'b1, 1'b1);
    check("R2", expect_out(ref_tab, 2'd2, 5'd12, 5'd0, 1'b1, 1'b1));
    drive(2'd2, 5'd3, 5'd0, 1'b1, 1'b1);
    check("R2", expect_out(ref_tab, 2'd2, 5'd3, 5'd0, 1'b1, 1'b1));
    drive(2'd1, 5'd29, 5'd29, 1'b0, 1'b0);
    check("R2", expect_out(ref_tab, 2'd1, 5'd29, 5'd29, 1'b0, 1'b0));

    // R8: inputs changed while clock is high, outputs follow at once
    @(posedge clk);
    #2;
    drive(2'd2, 5'd27, 5'd0, 1'b1, 1'b1);
    check("R8", expect_out(ref_tab, 2'd2, 5'd27, 5'd0, 1'b1, 1'b1));
    drive(2'd0, 5'd6, 5'd25, 1'b0, 1'b0);
    check("R8", expect_out(ref_tab, 2'd0, 5'd6, 5'd25, 1'b0, 1'b0));

    // R1: reset again mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    ref_tab = '0;
    drive(2'd2, 5'd27, 5'd9, 1'b1, 1'b1);
    check("R1", 7'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(2'd1, 5'd27, 5'd9, 1'b0, 1'b0);
    check("R1", 7'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule